// File: doc/BRIEF.md
# Dual-Bank Clock Configuration Switcher

This block keeps two complete divider configurations for one output clock and a single select register that names the bank in use. Each bank holds a source code for the clock mux in front of it, a pre-divider field and the settings of a fractional M/N counter. The surrounding clock generators read the bank contents and the select value. They are not part of the block.

A request carries a parent index, a divide ratio and M and N values. A sequencer checks the request. It translates the parent index into a hardware source code through a parameter table and writes the settings in a fixed order. If the output clock is enabled, the sequencer programs the bank that is not in use and flips the select as its last step, so the output never runs from a half-written setting. If the output is disabled, it rewrites the active bank in place. The active bank and its decoded settings are always visible on the status outputs.

Top module: `dbank_clk_cfg`

## Requirements
- R1: After reset, act_bank is 0, busy, req_rej, mn_rst and bank_mn_en are all 0, act_src is the code of parent index 0, and act_div, act_m, act_n and act_mn_en are 0.
- R2: A request accepted while out_en is 1 programs the bank opposite to act_bank. act_bank flips only on the last busy cycle, and it then reports the new settings.
- R3: busy rises on the clock edge that accepts a request and stays high for exactly 6 cycles. act_bank settles on the edge where busy falls.
- R4: A request accepted while out_en is 0 rewrites the active bank in place, and act_bank does not change.
- R5: act_src is the hardware code looked up from the parent index, not the index itself. With the default table, indices 0, 1, 2, 3 and 4 map to codes 0, 2, 1, 5 and 6.
- R6: The pre-divider field act_div holds the divide ratio minus one. Ratios 1 to 16 are accepted.
- R7: With N nonzero, act_m and act_n read back the requested M and N, and act_mn_en is 1. With N equal to 0 the counter is bypassed: act_m, act_n and act_mn_en are 0.
- R8: Only the bank being programmed has its mn_rst bit set. The bit is high for exactly the 4 cycles in which the counter values are written, and it is low before the select flips.
- R9: A request with parent index of 5 or more, a ratio of 0 or above 16, or nonzero N with M equal to 0 or M above N gives a one-cycle req_rej pulse on the next cycle. busy stays low and every status output is unchanged.
- R10: A request that arrives while busy is high is rejected with req_rej and does not disturb the sequence in progress.
- R11: With SHARED_CFG=0, bank_mn_en holds one counter-enable bit per bank, bit b for bank b. With SHARED_CFG=1, a single enable is shared by both banks, and both bits follow the last programmed request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| out_en | input | 1 | Output clock currently enabled |
| req_valid | input | 1 | One-cycle configuration request strobe |
| req_parent | input | PIDX_W | Requested parent index |
| req_div | input | PDIV_W+1 | Requested divide ratio (1 to 2^PDIV_W) |
| req_m | input | MN_W | Requested M value |
| req_n | input | MN_W | Requested N value, 0 bypasses the counter |
| busy | output | 1 | Reconfiguration sequence in progress |
| req_rej | output | 1 | Pulse: last request rejected |
| act_bank | output | 1 | Active bank select (1 selects bank 1) |
| act_src | output | SRC_W | Source code of the active bank |
| act_div | output | PDIV_W | Pre-divider field of the active bank |
| act_m | output | MN_W | M value of the active bank |
| act_n | output | MN_W | Decoded N value of the active bank |
| act_mn_en | output | 1 | Counter enable of the active bank |
| bank_mn_en | output | 2 | Counter enable as seen by each bank |
| mn_rst | output | 2 | Counter reset per bank |

## Verification
Valid requests alternate between out_en high and low. This separates the ping-pong path, where the select flips and the other bank is written, from the in-place path. The parent indices cover several table entries whose code differs from the index, so the bench can tell a looked-up code from a raw index. The ratios include both ends of the range and the N values include zero, so the minus-one encoding and the bypass case are each seen. Malformed requests of each kind, and a request made while a sequence is running, show that rejection leaves the active settings intact. A second instance with a shared enable shows how the counter-enable storage differs from the per-bank case.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_RST  = 3'd1,
      ST_M    = 3'd2,
      ST_N    = 3'd3,
      ST_MODE = 3'd4,
      ST_REL  = 3'd5,
      ST_FLIP = 3'd6
   } seq_st_e;
endpackage

// File: rtl/dbc_bank.sv
module dbc_bank #(
   parameter int SRC_W  = 3,
   parameter int PDIV_W = 4,
   parameter int MN_W   = 8,
   parameter logic [SRC_W-1:0] RST_CODE = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_m,
   input  logic              wr_n,
   input  logic              wr_ds,
   input  logic              set_rst,
   input  logic              clr_rst,
   input  logic [SRC_W-1:0]  code_in,
   input  logic [PDIV_W-1:0] divf_in,
   input  logic [MN_W-1:0]   m_in,
   input  logic [MN_W-1:0]   nm_in,
   output logic [SRC_W-1:0]  code,
   output logic [PDIV_W-1:0] divf,
   output logic [MN_W-1:0]   m,
   output logic [MN_W-1:0]   nm,
   output logic              cnt_rst
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code    <= RST_CODE;
         divf    <= '0;
         m       <= '0;
         nm      <= '1;
         cnt_rst <= 1'b0;
      end else begin
         if (wr_m)    m  <= m_in;
         if (wr_n)    nm <= nm_in;
         if (wr_ds) begin
            code <= code_in;
            divf <= divf_in;
         end
         if (set_rst)      cnt_rst <= 1'b1;
         else if (clr_rst) cnt_rst <= 1'b0;
      end
   end
endmodule

// File: rtl/dbc_seq.sv
module dbc_seq
   import dbc_pkg::*;
#(
   parameter int PIDX_W  = 3,
   parameter int NUM_PAR = 5,
   parameter int SRC_W   = 3,
   parameter int PDIV_W  = 4,
   parameter int MN_W    = 8,
   parameter logic [NUM_PAR*SRC_W-1:0] PARENT_MAP = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_en,
   input  logic              sel,
   input  logic              req_valid,
   input  logic [PIDX_W-1:0] req_parent,
   input  logic [PDIV_W:0]   req_div,
   input  logic [MN_W-1:0]   req_m,
   input  logic [MN_W-1:0]   req_n,
   output logic              busy,
   output logic              rej,
   output logic              tgt,
   output logic              set_rst,
   output logic              clr_rst,
   output logic              wr_m,
   output logic              wr_n,
   output logic              wr_mode,
   output logic              wr_ds,
   output logic              flip,
   output logic [SRC_W-1:0]  lat_code,
   output logic [PDIV_W-1:0] lat_divf,
   output logic [MN_W-1:0]   lat_m,
   output logic [MN_W-1:0]   lat_nm,
   output logic              lat_en
);
   localparam logic [PDIV_W:0] DIV_MAX = (PDIV_W+1)'(2**PDIV_W);

   seq_st_e st;
   logic    tog;
   logic    ok;
   logic    mn_ok;

   assign mn_ok = (req_n == '0) || ((req_m != '0) && (req_m <= req_n));
   assign ok    = (int'(req_parent) < NUM_PAR) && (req_div != '0) &&
                  (req_div <= DIV_MAX) && mn_ok;

   assign busy    = (st != ST_IDLE);
   assign set_rst = (st == ST_RST);
   assign wr_m    = (st == ST_M);
   assign wr_n    = (st == ST_N);
   assign wr_mode = (st == ST_MODE);
   assign wr_ds   = (st == ST_REL);
   assign clr_rst = (st == ST_REL);
   assign flip    = (st == ST_FLIP) && tog;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         rej      <= 1'b0;
         tgt      <= 1'b0;
         tog      <= 1'b0;
         lat_code <= '0;
         lat_divf <= '0;
         lat_m    <= '0;
         lat_nm   <= '1;
         lat_en   <= 1'b0;
      end else begin
         rej <= req_valid && (busy || !ok);
         case (st)
            ST_IDLE: if (req_valid && ok) begin
               st       <= ST_RST;
               tog      <= out_en;
               tgt      <= out_en ? ~sel : sel;
               lat_code <= PARENT_MAP[int'(req_parent)*SRC_W +: SRC_W];
               lat_divf <= PDIV_W'(req_div - 1'b1);
               lat_en   <= (req_n != '0);
               lat_m    <= (req_n != '0) ? req_m : '0;
               lat_nm   <= (req_n != '0) ? ~(req_n - req_m) : '1;
            end
            ST_RST:  st <= ST_M;
            ST_M:    st <= ST_N;
            ST_N:    st <= ST_MODE;
            ST_MODE: st <= ST_REL;
            ST_REL:  st <= ST_FLIP;
            default: st <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dbank_clk_cfg.sv
module dbank_clk_cfg #(
   parameter int PIDX_W     = 3,
   parameter int NUM_PAR    = 5,
   parameter int SRC_W      = 3,
   parameter int PDIV_W     = 4,
   parameter int MN_W       = 8,
   parameter bit SHARED_CFG = 1'b0,
   parameter logic [NUM_PAR*SRC_W-1:0] PARENT_MAP = {3'd6, 3'd5, 3'd1, 3'd2, 3'd0}
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              out_en,
   input  logic              req_valid,
   input  logic [PIDX_W-1:0] req_parent,
   input  logic [PDIV_W:0]   req_div,
   input  logic [MN_W-1:0]   req_m,
   input  logic [MN_W-1:0]   req_n,
   output logic              busy,
   output logic              req_rej,
   output logic              act_bank,
   output logic [SRC_W-1:0]  act_src,
   output logic [PDIV_W-1:0] act_div,
   output logic [MN_W-1:0]   act_m,
   output logic [MN_W-1:0]   act_n,
   output logic              act_mn_en,
   output logic [1:0]        bank_mn_en,
   output logic [1:0]        mn_rst
);
   localparam int NBANK = 2;
   localparam logic [SRC_W-1:0] CODE0 = PARENT_MAP[SRC_W-1:0];

   if (NUM_PAR < 1 || NUM_PAR > 2**PIDX_W) begin : g_bad_npar
      $error("NUM_PAR must fit in PIDX_W bits");
   end
   if (PDIV_W < 1 || MN_W < 2 || SRC_W < 1) begin : g_bad_width
      $error("field widths out of range");
   end

   logic              sel;
   logic              tgt, set_rst, clr_rst, wr_m, wr_n, wr_mode, wr_ds, flip;
   logic [SRC_W-1:0]  lat_code;
   logic [PDIV_W-1:0] lat_divf;
   logic [MN_W-1:0]   lat_m, lat_nm;
   logic              lat_en;

   logic [SRC_W-1:0]  b_code [NBANK];
   logic [PDIV_W-1:0] b_divf [NBANK];
   logic [MN_W-1:0]   b_m    [NBANK];
   logic [MN_W-1:0]   b_nm   [NBANK];

   dbc_seq #(
      .PIDX_W(PIDX_W), .NUM_PAR(NUM_PAR), .SRC_W(SRC_W), .PDIV_W(PDIV_W),
      .MN_W(MN_W), .PARENT_MAP(PARENT_MAP)
   ) u_seq (
      .clk(clk), .rst_n(rst_n), .out_en(out_en), .sel(sel),
      .req_valid(req_valid), .req_parent(req_parent), .req_div(req_div),
      .req_m(req_m), .req_n(req_n), .busy(busy), .rej(req_rej), .tgt(tgt),
      .set_rst(set_rst), .clr_rst(clr_rst), .wr_m(wr_m), .wr_n(wr_n),
      .wr_mode(wr_mode), .wr_ds(wr_ds), .flip(flip), .lat_code(lat_code),
      .lat_divf(lat_divf), .lat_m(lat_m), .lat_nm(lat_nm), .lat_en(lat_en)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit;
      assign hit = (tgt == 1'(b));
      dbc_bank #(
         .SRC_W(SRC_W), .PDIV_W(PDIV_W), .MN_W(MN_W), .RST_CODE(CODE0)
      ) u_bank (
         .clk(clk), .rst_n(rst_n),
         .wr_m(wr_m && hit), .wr_n(wr_n && hit), .wr_ds(wr_ds && hit),
         .set_rst(set_rst && hit), .clr_rst(clr_rst && hit),
         .code_in(lat_code), .divf_in(lat_divf), .m_in(lat_m), .nm_in(lat_nm),
         .code(b_code[b]), .divf(b_divf[b]), .m(b_m[b]), .nm(b_nm[b]),
         .cnt_rst(mn_rst[b])
      );
   end

   if (SHARED_CFG) begin : g_mode_shared
      logic sh_en;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       sh_en <= 1'b0;
         else if (wr_mode) sh_en <= lat_en;
      end
      assign bank_mn_en = {NBANK{sh_en}};
   end else begin : g_mode_split
      for (genvar b = 0; b < NBANK; b++) begin : g_en
         logic en_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          en_q <= 1'b0;
            else if (wr_mode && tgt == 1'(b))    en_q <= lat_en;
         end
         assign bank_mn_en[b] = en_q;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sel <= 1'b0;
      else if (flip) sel <= ~sel;
   end

   assign act_bank  = sel;
   assign act_src   = b_code[sel];
   assign act_div   = b_divf[sel];
   assign act_m     = b_m[sel];
   assign act_n     = ~b_nm[sel] + b_m[sel];
   assign act_mn_en = bank_mn_en[sel];
endmodule

module dbc_chk #(
   parameter int PIDX_W  = 3,
   parameter int NUM_PAR = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [PIDX_W-1:0] req_parent,
   input logic              busy,
   input logic              req_rej,
   input logic              act_bank,
   input logic [1:0]        mn_rst
);
   AST_IDLE_HOLDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> $stable(act_bank)); // R2
   AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && busy) |=> req_rej); // R10
   AST_RST_ONE_BANK: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mn_rst)); // R8
   AST_RST_LOW_AT_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(act_bank) |-> (mn_rst == 2'b00)); // R8
   AST_BAD_PARENT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy && int'(req_parent) >= NUM_PAR) |=> (req_rej && !busy)); // R9
   AST_RST_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (mn_rst != 2'b00) |-> busy); // R8
endmodule

bind dbank_clk_cfg dbc_chk #(.PIDX_W(PIDX_W), .NUM_PAR(NUM_PAR)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_parent(req_parent),
   .busy(busy), .req_rej(req_rej), .act_bank(act_bank), .mn_rst(mn_rst)
);

// File: tb/sim_dbank_clk_cfg.sv
`timescale 1ns/1ps
module sim_dbank_clk_cfg;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       out_en = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_parent = '0;
   logic [4:0] req_div = '0;
   logic [7:0] req_m = '0;
   logic [7:0] req_n = '0;

   logic       busy, rej, act_bank, act_mn_en;
   logic [2:0] act_src;
   logic [3:0] act_div;
   logic [7:0] act_m, act_n;
   logic [1:0] bank_mn_en, mn_rst;

   logic       busy1, rej1, bank1, mn_en1;
   logic [2:0] src1;
   logic [3:0] div1;
   logic [7:0] m1, n1;
   logic [1:0] bank_en1, rst1;

   int  nchk = 0;
   int  nfail = 0;
   bit  done = 0;
   logic       exp_sel = 1'b0;
   logic [1:0] exp_en = 2'b00;

   always #2.5 clk = ~clk;

   dbank_clk_cfg u0 (
      .clk(clk), .rst_n(rst_n), .out_en(out_en), .req_valid(req_valid),
      .req_parent(req_parent), .req_div(req_div), .req_m(req_m), .req_n(req_n),
      .busy(busy), .req_rej(rej), .act_bank(act_bank), .act_src(act_src),
      .act_div(act_div), .act_m(act_m), .act_n(act_n), .act_mn_en(act_mn_en),
      .bank_mn_en(bank_mn_en), .mn_rst(mn_rst)
   );

   dbank_clk_cfg #(.SHARED_CFG(1'b1)) u1 (
      .clk(clk), .rst_n(rst_n), .out_en(out_en), .req_valid(req_valid),
      .req_parent(req_parent), .req_div(req_div), .req_m(req_m), .req_n(req_n),
      .busy(busy1), .req_rej(rej1), .act_bank(bank1), .act_src(src1),
      .act_div(div1), .act_m(m1), .act_n(n1), .act_mn_en(mn_en1),
      .bank_mn_en(bank_en1), .mn_rst(rst1)
   );

   function automatic logic [2:0] code_of(input int idx);
      case (idx)
         0: return 3'd0;
         1: return 3'd2;
         2: return 3'd1;
         3: return 3'd5;
         default: return 3'd6;
      endcase
   endfunction

   task automatic chk(input string tag, input longint act, input longint exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic send(input int p, input int d, input int m, input int n, input bit en);
      @(negedge clk);
      out_en     = en;
      req_valid  = 1'b1;
      req_parent = 3'(p);
      req_div    = 5'(d);
      req_m      = 8'(m);
      req_n      = 8'(n);
      @(negedge clk);
      req_valid  = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1 act_bank", act_bank, 0);
      chk("R1 busy", busy, 0);
      chk("R1 rej", rej, 0);
      chk("R1 mn_rst", mn_rst, 0);
      chk("R1 bank_mn_en", bank_mn_en, 0);
      chk("R1 act_src", act_src, code_of(0));
      chk("R1 act_div", act_div, 0);
      chk("R1 act_m", act_m, 0);
      chk("R1 act_n", act_n, 0);
      chk("R1 act_mn_en", act_mn_en, 0);
   endtask

   task automatic t_valid(input int p, input int d, input int m, input int n, input bit en);
      logic tgt;
      int   bcnt = 0;
      int   rcnt = 0;
      bit   rbad = 0;
      tgt = en ? ~exp_sel : exp_sel;
      send(p, d, m, n, en);
      chk("R3 no reject on valid request", rej, 0);
      while (busy && bcnt < 20) begin
         bcnt++;
         if (mn_rst != 2'b00) begin
            rcnt++;
            if (mn_rst != (2'b01 << tgt)) rbad = 1;
         end
         if (bcnt == 6) chk("R2 select held until last busy cycle", act_bank, exp_sel);
         @(negedge clk);
      end
      chk("R3 busy cycles", bcnt, 6);
      chk("R8 counter reset cycles", rcnt, 4);
      chk("R8 reset only on target bank", rbad, 0);
      exp_sel = tgt;
      exp_en[tgt] = (n != 0);
      chk(en ? "R2 bank flipped" : "R4 bank kept", act_bank, exp_sel);
      chk("R5 source code", act_src, code_of(p));
      chk("R6 divider field", act_div, d - 1);
      chk("R7 m", act_m, (n != 0) ? m : 0);
      chk("R7 n", act_n, n);
      chk("R7 counter enable", act_mn_en, (n != 0));
      chk("R11 per-bank enables", bank_mn_en, exp_en);
      chk("R11 shared enables", bank_en1, (n != 0) ? 3 : 0);
   endtask

   task automatic t_bad(input string why, input int p, input int d, input int m, input int n);
      logic       s_bank;
      logic [2:0] s_src;
      logic [3:0] s_div;
      logic [7:0] s_m, s_n;
      s_bank = act_bank; s_src = act_src; s_div = act_div; s_m = act_m; s_n = act_n;
      send(p, d, m, n, 1'b1);
      chk({"R9 reject pulse ", why}, rej, 1);
      chk({"R9 no busy ", why}, busy, 0);
      @(negedge clk);
      chk({"R9 pulse one cycle ", why}, rej, 0);
      chk({"R9 bank unchanged ", why}, act_bank, s_bank);
      chk({"R9 src unchanged ", why}, act_src, s_src);
      chk({"R9 div unchanged ", why}, act_div, s_div);
      chk({"R9 m unchanged ", why}, act_m, s_m);
      chk({"R9 n unchanged ", why}, act_n, s_n);
   endtask

   task automatic t_busy_reject();
      int bcnt = 0;
      logic tgt;
      tgt = ~exp_sel;
      send(2, 4, 3, 7, 1'b1);
      out_en = 1'b1; req_valid = 1'b1; req_parent = 3'd3; req_div = 5'd9;
      req_m = 8'd1; req_n = 8'd2;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R10 reject while busy", rej, 1);
      while (busy && bcnt < 20) begin bcnt++; @(negedge clk); end
      exp_sel = tgt;
      exp_en[tgt] = 1'b1;
      chk("R10 first request completes", act_bank, exp_sel);
      chk("R10 src from first request", act_src, code_of(2));
      chk("R10 div from first request", act_div, 3);
      chk("R10 n from first request", act_n, 7);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_valid(1, 3, 1, 3, 1'b1);
      t_valid(3, 16, 0, 0, 1'b0);
      t_valid(4, 1, 5, 255, 1'b1);
      t_valid(0, 2, 0, 0, 1'b1);
      t_bad("parent", 5, 2, 1, 2);
      t_bad("ratio zero", 1, 0, 1, 2);
      t_bad("ratio high", 1, 17, 1, 2);
      t_bad("m above n", 1, 2, 4, 3);
      t_bad("m zero", 1, 2, 0, 3);
      t_busy_reject();
      t_valid(2, 7, 200, 200, 1'b0);
      done = 1;
      $display("  %0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         nchk++;
         nfail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  %0d/%0d checks passed", nchk - nfail, nchk);
         $finish;
      end
   end
endmodule